// File: doc/BRIEF.md
# Byte-wide SPI controller with bus-takeover detection

A full-duplex serial peripheral interface engine that moves one byte at a time. It acts either as the bus master or as a slave, and an 8-bit control register sets it up. As master it makes the serial clock from the system clock through a four-step rate divider. It shifts the byte out on its data-out line while it shifts the reply in. As slave it follows an external serial clock and an active-low select input, and both pass through two-flop synchronisers before edge detection.

When select is configured as an input, the master watches it for another master that takes the bus. A low level demotes the block to slave at once. The serial clock and data-out drivers are released and the completion flag rises. In slave mode, a rising select aborts the byte in progress. The bit counter and the partial receive bits are dropped, and the transmit side is reloaded, so the next select window starts on a clean byte boundary. A completion flag with an explicit clear strobe and a gated interrupt request report finished bytes and faults.

Top module: `spi_port`

## Requirements
- R1: The control register resets to 0x00, reads back what was written, and holds, from bit 7 down to bit 0: interrupt enable, enable, LSB-first, master, clock polarity, clock phase and a 2-bit rate select.
- R2: With the enable bit at 0 no transfer starts, no SCK edge appears, the flag stays low and no pin output-enable is set, even with master set or select low.
- R3: In slave mode with select low, only the MISO output-enable is set, and the byte clocked in on MOSI appears on rxData after the eighth sampling edge.
- R4: In slave mode a rising select drops the partial byte and clears the bit count. The flag does not rise, MISO is released, and the next full byte is received and sent whole.
- R5: In master mode with ssDirOut=1, ssOe is 1 and ssOut follows ssDrive. A low select input then has no effect on the transfer.
- R6: In master mode with ssDirOut=0, a low synchronised select clears the master bit, releases SCK and MOSI, and sets the flag.
- R7: irq is 1 exactly when the flag, the interrupt-enable bit and globalIrqEn are all 1. flagClr clears the flag, and a set in the same cycle wins.
- R8: After a mode fault the master bit stays 0 until software writes it to 1.
- R9: The flag sets after each byte: for master at the end of the 16th SCK half period, for slave on the 8th sampling edge. rxData then holds the received byte.
- R10: LSB-first=1 sends and receives bit 0 first; LSB-first=0 sends bit 7 first.
- R11: SCK idles at the polarity bit. Phase 0 samples on the leading edge and launches on the trailing edge; phase 1 does the reverse.
- R12: In master mode rate select 0, 1, 2, 3 gives an SCK half period of 2, 8, 32 and 64 system clocks (divide by 4, 16, 64, 128), and a transfer has exactly 16 SCK edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 8 | Control register write value |
| regRdData | output | 8 | Control register read value |
| dataWrEn | input | 1 | Data write strobe: loads the transmit byte; starts a master transfer |
| dataWrData | input | W | Transmit byte |
| rxData | output | W | Last completely received byte |
| flagClr | input | 1 | Completion flag clear strobe |
| globalIrqEn | input | 1 | Global interrupt enable |
| doneFlag | output | 1 | Byte-complete or mode-fault flag |
| irq | output | 1 | Interrupt request |
| ssDirOut | input | 1 | In master mode, 1 makes select a plain output |
| ssDrive | input | 1 | Level driven on select when it is an output |
| sckIn | input | 1 | Serial clock from the pin |
| sckOut | output | 1 | Serial clock to the pin |
| sckOe | output | 1 | Serial clock output-enable |
| mosiIn | input | 1 | Master-out line from the pin |
| mosiOut | output | 1 | Master-out line to the pin |
| mosiOe | output | 1 | Master-out output-enable |
| misoIn | input | 1 | Master-in line from the pin |
| misoOut | output | 1 | Master-in line to the pin |
| misoOe | output | 1 | Master-in output-enable |
| ssIn | input | 1 | Select line from the pin, active low |
| ssOut | output | 1 | Select line to the pin |
| ssOe | output | 1 | Select output-enable |

## Verification
The bench builds the block with the default 8-bit byte. At that width every master setting can be swept: all 32 combinations of polarity, phase, bit order and rate, with MISO looped back to MOSI. The serial bit order, the half-period spacing and the received byte are each checked against arithmetic in the bench. A model external master then runs all 8 slave combinations of polarity, phase and order. It also covers a select abort after three bits and a bus takeover with the interrupt gating around it.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  // longest SCK half period in system clocks (rate select 3)
  localparam int HALF_TOP = 64;

  // control register, field order is the register bit order (7 downto 0)
  typedef struct packed {
    logic       intEn;
    logic       enable;
    logic       lsbFirst;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } ctrlReg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;      // drop bit count, partial receive bits, pending reload
    logic startLoad;  // master start: load transmit byte from write data
    logic holdLoad;   // idle or aborted: load transmit byte from hold register
    logic launch;     // drive next bit
    logic sample;     // capture incoming bit
  } dpStrobe_t;

endpackage

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
  import spi_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  input  logic       dataWrEn,
  input  logic       flagClr,
  input  logic       globalIrqEn,
  input  logic       ssDirOut,
  input  logic       sckIn,
  input  logic       ssIn,
  input  logic       byteDone,
  output ctrlReg_t   cfg,
  output dpStrobe_t  stb,
  output logic       masterOn,
  output logic       slaveOn,
  output logic       sckLvl,
  output logic       doneFlag,
  output logic       irq
);

  localparam int DIV_W    = $clog2(HALF_TOP);
  localparam int HALF_CNT = 2 * W;
  localparam int HIDX_W   = $clog2(HALF_CNT);

  logic [1:0]        sckSync;
  logic [1:0]        ssSync;
  logic              sckPrev;
  logic              busy;
  logic [DIV_W-1:0]  divCnt;
  logic [HIDX_W-1:0] halfIdx;
  logic [DIV_W:0]    halfLen;
  logic              ssLow;
  logic              faultNow;
  logic              start;
  logic              tick;
  logic              lastHalf;
  logic              mLead;
  logic              mSample;
  logic              mLaunch;
  logic              sEdge;
  logic              sLead;
  logic              sTrail;
  logic              flagSet;

  assign ssLow    = ~ssSync[1];
  assign masterOn = cfg.enable & cfg.master;
  assign slaveOn  = cfg.enable & ~cfg.master & ssLow;
  assign faultNow = masterOn & ~ssDirOut & ssLow;
  assign start    = masterOn & ~busy & dataWrEn & ~faultNow;

  // half period: 2, 8, 32 for rate 0..2, top value for rate 3
  always_comb begin
    if (cfg.rate == 2'd3) halfLen = (DIV_W+1)'(HALF_TOP);
    else                  halfLen = (DIV_W+1)'(2) << {cfg.rate, 1'b0};
  end

  assign tick     = busy & ({1'b0, divCnt} == halfLen - 1'b1);
  assign lastHalf = (halfIdx == HIDX_W'(HALF_CNT - 1));
  assign mLead    = ~halfIdx[0];
  assign mSample  = tick & (cfg.cpha ? ~mLead : mLead);
  assign mLaunch  = tick & (cfg.cpha ? mLead : ~mLead);

  assign sEdge  = slaveOn & (sckSync[1] ^ sckPrev);
  assign sLead  = sEdge & (sckSync[1] != cfg.cpol);
  assign sTrail = sEdge & ~sLead;

  always_comb begin
    stb.holdLoad  = (~masterOn & ~slaveOn) | faultNow;
    stb.startLoad = start;
    stb.clear     = stb.holdLoad | start;
    stb.sample    = mSample | (cfg.cpha ? sTrail : sLead);
    stb.launch    = mLaunch | (cfg.cpha ? sLead : sTrail);
  end

  assign flagSet = faultNow | (tick & lastHalf) | (slaveOn & byteDone);
  assign irq     = doneFlag & cfg.intEn & globalIrqEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckSync  <= '0;
      ssSync   <= '1;
      sckPrev  <= 1'b0;
      cfg      <= '0;
      busy     <= 1'b0;
      divCnt   <= '0;
      halfIdx  <= '0;
      sckLvl   <= 1'b0;
      doneFlag <= 1'b0;
    end else begin
      sckSync <= {sckSync[0], sckIn};
      ssSync  <= {ssSync[0], ssIn};
      sckPrev <= sckSync[1];

      if (regWrEn) cfg <= regWrData;
      if (faultNow) cfg.master <= 1'b0;

      if (faultNow || !masterOn) begin
        busy   <= 1'b0;
        sckLvl <= cfg.cpol;
      end else if (start) begin
        busy    <= 1'b1;
        divCnt  <= '0;
        halfIdx <= '0;
      end else if (busy) begin
        if (tick) begin
          divCnt  <= '0;
          sckLvl  <= ~sckLvl;
          halfIdx <= halfIdx + 1'b1;
          if (lastHalf) busy <= 1'b0;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end else begin
        sckLvl <= cfg.cpol;
      end

      if (flagSet)      doneFlag <= 1'b1;
      else if (flagClr) doneFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_port_dp.sv
module spi_port_dp
  import spi_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  dpStrobe_t    stb,
  input  logic         lsbFirst,
  input  logic         cpha,
  input  logic         inBit,
  input  logic         dataWrEn,
  input  logic [W-1:0] wrData,
  output logic         outBit,
  output logic [W-1:0] rxData,
  output logic         byteDone
);

  localparam int CNT_W = $clog2(W);

  logic [W-1:0]     txHold;
  logic [W-1:0]     txReg;
  logic [W-1:0]     rxReg;
  logic [W-1:0]     rxNext;
  logic [W-1:0]     loadSrc;
  logic [W-1:0]     launchSrc;
  logic [CNT_W-1:0] bitCnt;
  logic             pendReload;
  logic             lastBit;

  function automatic logic firstOf(input logic [W-1:0] v, input logic lsb);
    return lsb ? v[0] : v[W-1];
  endfunction

  function automatic logic [W-1:0] dropFirst(input logic [W-1:0] v, input logic lsb);
    return lsb ? (v >> 1) : (v << 1);
  endfunction

  assign rxNext    = lsbFirst ? {inBit, rxReg[W-1:1]} : {rxReg[W-2:0], inBit};
  assign loadSrc   = stb.startLoad ? wrData : txHold;
  assign launchSrc = pendReload ? txHold : txReg;
  assign lastBit   = (bitCnt == CNT_W'(W - 1));
  assign byteDone  = stb.sample & lastBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txHold     <= '0;
      txReg      <= '0;
      rxReg      <= '0;
      rxData     <= '0;
      bitCnt     <= '0;
      pendReload <= 1'b0;
      outBit     <= 1'b0;
    end else begin
      if (dataWrEn) txHold <= wrData;

      if (stb.clear) begin
        rxReg      <= '0;
        bitCnt     <= '0;
        pendReload <= 1'b0;
      end

      if (stb.startLoad || stb.holdLoad) begin
        if (!cpha) begin
          outBit <= firstOf(loadSrc, lsbFirst);
          txReg  <= dropFirst(loadSrc, lsbFirst);
        end else begin
          txReg <= loadSrc;
        end
      end else begin
        if (stb.launch) begin
          outBit     <= firstOf(launchSrc, lsbFirst);
          txReg      <= dropFirst(launchSrc, lsbFirst);
          pendReload <= 1'b0;
        end
        if (stb.sample) begin
          if (lastBit) begin
            rxData <= rxNext;
            rxReg  <= '0;
            bitCnt <= '0;
            if (cpha) txReg <= txHold;
            else      pendReload <= 1'b1;
          end else begin
            rxReg  <= rxNext;
            bitCnt <= bitCnt + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         regWrEn,
  input  logic [7:0]   regWrData,
  output logic [7:0]   regRdData,
  input  logic         dataWrEn,
  input  logic [W-1:0] dataWrData,
  output logic [W-1:0] rxData,
  input  logic         flagClr,
  input  logic         globalIrqEn,
  output logic         doneFlag,
  output logic         irq,
  input  logic         ssDirOut,
  input  logic         ssDrive,
  input  logic         sckIn,
  output logic         sckOut,
  output logic         sckOe,
  input  logic         mosiIn,
  output logic         mosiOut,
  output logic         mosiOe,
  input  logic         misoIn,
  output logic         misoOut,
  output logic         misoOe,
  input  logic         ssIn,
  output logic         ssOut,
  output logic         ssOe
);

  ctrlReg_t  cfg;
  dpStrobe_t stb;
  logic      masterOn;
  logic      slaveOn;
  logic      sckLvl;
  logic      outBit;
  logic      byteDone;
  logic      inBit;

  assign inBit = masterOn ? misoIn : mosiIn;

  spi_port_ctrl #(.W(W)) ctrlI (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regWrData(regWrData),
    .dataWrEn(dataWrEn), .flagClr(flagClr), .globalIrqEn(globalIrqEn),
    .ssDirOut(ssDirOut), .sckIn(sckIn), .ssIn(ssIn), .byteDone(byteDone),
    .cfg(cfg), .stb(stb), .masterOn(masterOn), .slaveOn(slaveOn),
    .sckLvl(sckLvl), .doneFlag(doneFlag), .irq(irq)
  );

  spi_port_dp #(.W(W)) dpI (
    .clk(clk), .rstN(rstN), .stb(stb),
    .lsbFirst(cfg.lsbFirst), .cpha(cfg.cpha), .inBit(inBit),
    .dataWrEn(dataWrEn), .wrData(dataWrData),
    .outBit(outBit), .rxData(rxData), .byteDone(byteDone)
  );

  assign regRdData = cfg;
  assign sckOut    = sckLvl;
  assign sckOe     = masterOn;
  assign mosiOut   = outBit;
  assign mosiOe    = masterOn;
  assign misoOut   = outBit;
  assign misoOe    = slaveOn;
  assign ssOut     = ssDrive;
  assign ssOe      = masterOn & ssDirOut;

endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic       clk,
  input logic       rstN,
  input logic       regWrEn,
  input logic [7:0] regWrData,
  input logic [7:0] regRdData,
  input logic       sckOe,
  input logic       mosiOe,
  input logic       misoOe,
  input logic       doneFlag,
  input logic       irq,
  input logic       masterOn,
  input logic       slaveOn,
  input logic       holdLoad
);

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !regRdData[6] |-> (!sckOe && !mosiOe && !misoOe)); // R2

  AST_SLAVE_PINS: assert property (@(posedge clk) disable iff (!rstN)
    misoOe |-> (!sckOe && !mosiOe)); // R3

  AST_QUIET_NO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (!slaveOn && !masterOn) |=> !$rose(doneFlag)); // R4

  AST_FAULT_DEMOTE: assert property (@(posedge clk) disable iff (!rstN)
    (holdLoad && masterOn) |=> (!regRdData[4] && doneFlag && !sckOe && !mosiOe)); // R6

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (doneFlag && regRdData[7])); // R7

  AST_MASTER_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (!regRdData[4] && !(regWrEn && regWrData[4])) |=> !regRdData[4]); // R8

endmodule

bind spi_port spi_port_chk chkI (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
  .regRdData(regRdData), .sckOe(sckOe), .mosiOe(mosiOe), .misoOe(misoOe),
  .doneFlag(doneFlag), .irq(irq), .masterOn(masterOn), .slaveOn(slaveOn),
  .holdLoad(stb.holdLoad)
);

// File: tb/spi_port_tb_top.sv
`timescale 1ns/1ps
module spi_port_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       dataWrEn = 1'b0;
  logic [7:0] dataWrData = '0;
  logic [7:0] rxData;
  logic       flagClr = 1'b0;
  logic       globalIrqEn = 1'b0;
  logic       doneFlag, irq;
  logic       ssDirOut = 1'b0;
  logic       ssDrive = 1'b1;
  logic       sckIn = 1'b0;
  logic       sckOut, sckOe;
  logic       mosiIn = 1'b0;
  logic       mosiOut, mosiOe;
  logic       misoIn;
  logic       misoOut, misoOe;
  logic       ssIn = 1'b1;
  logic       ssOut, ssOe;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;

  // monitor state for master transfers
  logic       monCpol = 1'b0;
  logic       monCpha = 1'b0;
  int         monHalf = 2;
  logic       prevSck = 1'b0;
  int         edgeCnt = 0;
  int         halfErr = 0;
  int         lastEdge = 0;
  int         capIdx = 0;
  logic [7:0] capVal = '0;

  always #10 clk = ~clk;

  assign misoIn = mosiOut; // loopback for master runs

  spi_port #(.W(8)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .dataWrEn(dataWrEn), .dataWrData(dataWrData),
    .rxData(rxData), .flagClr(flagClr), .globalIrqEn(globalIrqEn),
    .doneFlag(doneFlag), .irq(irq), .ssDirOut(ssDirOut), .ssDrive(ssDrive),
    .sckIn(sckIn), .sckOut(sckOut), .sckOe(sckOe),
    .mosiIn(mosiIn), .mosiOut(mosiOut), .mosiOe(mosiOe),
    .misoIn(misoIn), .misoOut(misoOut), .misoOe(misoOe),
    .ssIn(ssIn), .ssOut(ssOut), .ssOe(ssOe)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= 150000 && !finished) begin
      failures = failures + 1;
      $display("FAIL watchdog expired act=%0d exp=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (sckOut != prevSck) begin
      if (edgeCnt > 0 && (cyc - lastEdge) != monHalf) halfErr = halfErr + 1;
      lastEdge = cyc;
      edgeCnt = edgeCnt + 1;
      if (((sckOut != monCpol) ^ monCpha) && capIdx < 8) begin
        capVal[capIdx] = mosiOut;
        capIdx = capIdx + 1;
      end
    end
    prevSck = sckOut;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(input logic [7:0] v);
    @(negedge clk); regWrEn = 1'b1; regWrData = v;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic writeData(input logic [7:0] v);
    @(negedge clk); dataWrEn = 1'b1; dataWrData = v;
    @(negedge clk); dataWrEn = 1'b0;
  endtask

  task automatic clearFlag();
    @(negedge clk); flagClr = 1'b1;
    @(negedge clk); flagClr = 1'b0;
  endtask

  task automatic monReset(input logic cp, input logic ph, input int half);
    monCpol = cp; monCpha = ph; monHalf = half;
    edgeCnt = 0; halfErr = 0; capIdx = 0; capVal = '0;
  endtask

  task automatic waitFlag(input int maxCyc);
    for (int i = 0; i < maxCyc; i++) begin
      if (doneFlag) break;
      @(negedge clk);
    end
  endtask

  function automatic logic [7:0] serialOrder(input logic [7:0] b, input logic lsb);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[k] = lsb ? b[k] : b[7-k];
    return r;
  endfunction

  // model external master driving the slave; returns MISO bits in send order
  task automatic slaveSend(input logic [7:0] b, input int nbits, input logic cp,
                           input logic ph, input logic lsb, output logic [7:0] got);
    got = '0;
    for (int k = 0; k < nbits; k++) begin
      if (!ph) begin
        mosiIn = lsb ? b[k] : b[7-k];
        tick(8);
        got[k] = misoOut;
        sckIn = ~cp;
        tick(8);
        sckIn = cp;
      end else begin
        sckIn = ~cp;
        mosiIn = lsb ? b[k] : b[7-k];
        tick(8);
        got[k] = misoOut;
        sckIn = cp;
        tick(8);
      end
    end
  endtask

  initial begin
    logic [7:0] got;
    tick(5);
    rstN = 1'b1;
    tick(2);

    // R1 reset state
    chk(regRdData == 8'h00, "R1 reset ctrl", regRdData, 0);
    chk(!doneFlag && !irq, "R7 reset flag/irq", {doneFlag, irq}, 0);
    chk(!sckOe && !mosiOe && !misoOe && !ssOe, "R2 reset oe",
        {sckOe, mosiOe, misoOe, ssOe}, 0);

    // R2 disabled master: nothing happens
    ssDirOut = 1'b1;
    writeReg(8'b0001_0000);
    monReset(1'b0, 1'b0, 2);
    writeData(8'hFF);
    tick(400);
    chk(edgeCnt == 0 && !doneFlag && !sckOe && !mosiOe, "R2 disabled master",
        edgeCnt, 0);
    writeReg(8'h00);
    ssIn = 1'b0;
    tick(8);
    chk(!misoOe && !doneFlag, "R2 disabled slave", {misoOe, doneFlag}, 0);
    ssIn = 1'b1;
    tick(4);

    // master sweep, select as output and held low (R5)
    ssIn = 1'b0;
    for (int c = 0; c < 32; c++) begin
      logic [1:0] rate;
      logic ph, cp, lsb;
      logic [7:0] ctl, b;
      int half;
      rate = c[1:0]; ph = c[2]; cp = c[3]; lsb = c[4];
      half = (rate == 2'd3) ? 64 : (2 << (2 * rate));
      ctl = {1'b0, 1'b1, lsb, 1'b1, cp, ph, rate};
      b = 8'h3C ^ 8'(c * 29);
      ssDrive = c[0];
      writeReg(ctl);
      tick(3);
      chk(regRdData == ctl, "R1 ctrl readback", regRdData, ctl);
      chk(sckOut == cp, "R11 idle level", sckOut, cp);
      chk(ssOe && ssOut == ssDrive, "R5 select output", {ssOe, ssOut}, {1'b1, ssDrive});
      monReset(cp, ph, half);
      writeData(b);
      waitFlag(4000);
      tick(2);
      chk(doneFlag, "R9 master flag", doneFlag, 1);
      chk(rxData == b, "R9 master rx loopback", rxData, b);
      chk(capIdx == 8 && capVal == serialOrder(b, lsb), "R10 R11 mosi order",
          capVal, serialOrder(b, lsb));
      chk(edgeCnt == 16 && halfErr == 0, "R12 sck timing", edgeCnt * 256 + halfErr, 16 * 256);
      chk(sckOut == cp && regRdData[4], "R5 R11 end state", {sckOut, regRdData[4]}, {cp, 1'b1});
      clearFlag();
      chk(!doneFlag, "R7 flag clear", doneFlag, 0);
    end
    ssIn = 1'b1;
    tick(4);

    // slave sweep
    for (int c = 0; c < 8; c++) begin
      logic ph, cp, lsb;
      logic [7:0] hold, inB;
      ph = c[0]; cp = c[1]; lsb = c[2];
      hold = 8'h96 ^ 8'(c * 17);
      inB = 8'h4B + 8'(c * 23);
      sckIn = cp;
      writeReg({1'b0, 1'b1, lsb, 1'b0, cp, ph, 2'b00});
      writeData(hold);
      tick(4);
      ssIn = 1'b0;
      tick(8);
      chk(misoOe && !sckOe && !mosiOe, "R3 slave pins", {misoOe, sckOe, mosiOe}, 3'b100);
      slaveSend(inB, 8, cp, ph, lsb, got);
      tick(8);
      chk(rxData == inB, "R3 slave rx", rxData, inB);
      chk(got == serialOrder(hold, lsb), "R10 R11 miso order", got, serialOrder(hold, lsb));
      chk(doneFlag, "R9 slave flag", doneFlag, 1);
      ssIn = 1'b1;
      tick(6);
      chk(!misoOe, "R4 miso released", misoOe, 0);
      clearFlag();
    end

    // R4 abort mid-byte
    sckIn = 1'b0;
    writeReg({1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00});
    writeData(8'hC3);
    tick(4);
    ssIn = 1'b0;
    tick(8);
    slaveSend(8'hFF, 3, 1'b0, 1'b0, 1'b0, got);
    ssIn = 1'b1;
    tick(10);
    chk(!doneFlag, "R4 abort no flag", doneFlag, 0);
    ssIn = 1'b0;
    tick(8);
    slaveSend(8'h5A, 8, 1'b0, 1'b0, 1'b0, got);
    tick(8);
    chk(rxData == 8'h5A, "R4 byte after abort", rxData, 8'h5A);
    chk(got == serialOrder(8'hC3, 1'b0), "R4 send after abort", got, serialOrder(8'hC3, 1'b0));
    ssIn = 1'b1;
    tick(6);
    clearFlag();

    // R6 R7 R8 mode fault
    ssDirOut = 1'b0;
    globalIrqEn = 1'b0;
    writeReg({1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'b01});
    writeData(8'hAA);
    tick(20);
    chk(sckOe && !doneFlag, "R6 master before fault", {sckOe, doneFlag}, 2'b10);
    ssIn = 1'b0;
    tick(6);
    chk(!regRdData[4], "R6 master bit cleared", regRdData[4], 0);
    chk(!sckOe && !mosiOe, "R6 pins released", {sckOe, mosiOe}, 0);
    chk(doneFlag, "R6 fault flag", doneFlag, 1);
    chk(!irq, "R7 irq gated by global", irq, 0);
    globalIrqEn = 1'b1;
    tick(1);
    chk(irq, "R7 irq raised", irq, 1);
    ssIn = 1'b1;
    tick(30);
    chk(!regRdData[4], "R8 master stays clear", regRdData[4], 0);
    clearFlag();
    chk(!doneFlag && !irq, "R7 clear drops irq", {doneFlag, irq}, 0);
    writeReg({1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'b01});
    tick(2);
    chk(regRdData[4] && sckOe, "R8 master rewritten", {regRdData[4], sckOe}, 2'b11);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule